// File: doc/BRIEF.md
# Video Pixel to Link Byte Converter

This block turns a one-pixel-per-beat video stream into the byte sequence carried in the payload of a display-link pixel packet. A static format select chooses one of four uncompressed packings (two bytes, packed 18-bit, padded 18-bit and three bytes per pixel), or a raw mode that forwards compressed data as it arrives. The output is a byte stream with a valid/ready handshake, an end-of-line marker on the last payload byte and a start-of-frame marker on the first.

All pixel bits are collected in a small bit accumulator, so a packing whose pixels cross byte boundaries uses the same datapath as the byte-aligned ones. A separate monitor works out the payload length of the line from the programmed pixel count, for the packet builder downstream. It also keeps a sticky underrun flag that records the input running dry in the middle of a line while the output is waiting for data.

Top module: `p2b_converter`

## Requirements
- R1: While rst_n is low, m_valid is 0, underrun is 0 and s_tready is 1.
- R2: Input tdata carries G in bits [7:0], B in [15:8] and R in [23:16], each component taken from its top 8 bits. In format 3 each pixel gives three bytes in the order R, G, B.
- R3: In format 0 each pixel forms the 16-bit word {B[7:3], G[7:2], R[7:3]}, sent low byte first.
- R4: In format 1 each pixel forms the 18-bit word {B[7:2], G[7:2], R[7:2]}. Four consecutive pixels are concatenated with the first pixel in the least significant bits and sent as 9 bytes, least significant byte first. The line length must be a multiple of 4 pixels.
- R5: In format 2 each pixel gives three bytes in the order R, G, B, each holding the 6-bit component in bits [7:2] with bits [1:0] zero.
- R6: In format 4 each beat's tdata is forwarded unchanged as the bytes tdata[7:0], tdata[15:8] and tdata[23:16], in that order.
- R7: m_last is 1 exactly on the final byte of the line whose input beat carried s_tlast.
- R8: m_sof is 1 exactly on the first byte produced from a beat that carried s_tuser.
- R9: word_count equals 2*line_pix in format 0, (9*line_pix)/4 in format 1 and 3*line_pix in the other formats.
- R10: underrun is set one cycle after a cycle in which a line is open (a beat has been accepted and its tlast beat has not), s_tready and m_ready are 1 and s_tvalid is 0. It is never set between lines.
- R11: underrun stays set until urun_clr is asserted in a cycle with no new underrun, and is 0 one cycle later.
- R12: While m_valid is 1 and m_ready is 0, m_data, m_last and m_sof hold their values, and no byte is lost or duplicated.
- R13: s_tready and m_valid are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt | input | 3 | Static format select: 0 two-byte, 1 packed 18-bit, 2 padded 18-bit, 3 three-byte, 4 raw |
| line_pix | input | LINE_W | Pixels per line, static while a line is open |
| s_tdata | input | 3*COMP_W | Pixel beat |
| s_tvalid | input | 1 | Pixel beat valid |
| s_tready | output | 1 | Pixel beat accepted when high with s_tvalid |
| s_tuser | input | 1 | Start of frame on this beat |
| s_tlast | input | 1 | Last beat of the line |
| m_data | output | 8 | Payload byte |
| m_valid | output | 1 | Payload byte valid |
| m_ready | input | 1 | Downstream takes the byte |
| m_last | output | 1 | Final byte of the line |
| m_sof | output | 1 | First byte of the frame |
| word_count | output | LINE_W+2 | Payload bytes per line |
| underrun | output | 1 | Sticky input-starved flag |
| urun_clr | input | 1 | Clears underrun |

## Verification
The hardest condition to reach is an underrun. Ordinary random traffic never produces one, because the source keeps s_tvalid high from the first beat of a line to its last. The flag can only rise once the accumulator has drained completely inside an open line while the output is ready. The stimulus reaches this state on purpose: it forces m_ready high, sends one pixel and then withholds s_tvalid for a dozen cycles before the rest of the line. The random lines with idle gaps between them confirm that starvation outside a line leaves the flag clear.

// File: rtl/p2b_pkg.sv
package p2b_pkg;
   typedef enum logic [2:0] {
      FMT_RGB565  = 3'd0,
      FMT_RGB666P = 3'd1,
      FMT_RGB666L = 3'd2,
      FMT_RGB888  = 3'd3,
      FMT_RAW     = 3'd4
   } pix_fmt_e;

   localparam int BYTE_W = 8;
   localparam int SLOT_W = 24;
   localparam int NB_W   = 5;
endpackage

// File: rtl/p2b_pack.sv
module p2b_pack
   import p2b_pkg::*;
#(
   parameter int COMP_W = 8
) (
   input  logic [2:0]          fmt,
   input  logic [3*COMP_W-1:0] px,
   output logic [SLOT_W-1:0]   bits,
   output logic [NB_W-1:0]     nbits
);
   localparam int PX_W = 3 * COMP_W;

   logic [7:0] r8, g8, b8;

   generate
      if (COMP_W < 8) begin : g_bad_comp
         $error("p2b_pack: COMP_W must be at least 8");
      end
   endgenerate

   // components sit G low, B middle, R high; keep the top 8 bits of each
   assign g8 = px[COMP_W-1 -: 8];
   assign b8 = px[2*COMP_W-1 -: 8];
   assign r8 = px[PX_W-1 -: 8];

   always_comb begin
      case (pix_fmt_e'(fmt))
         FMT_RGB565: begin
            bits  = {8'd0, b8[7:3], g8[7:2], r8[7:3]};
            nbits = NB_W'(16);
         end
         FMT_RGB666P: begin
            bits  = {6'd0, b8[7:2], g8[7:2], r8[7:2]};
            nbits = NB_W'(18);
         end
         FMT_RGB666L: begin
            bits  = {b8[7:2], 2'b00, g8[7:2], 2'b00, r8[7:2], 2'b00};
            nbits = NB_W'(24);
         end
         FMT_RAW: begin
            bits  = px[SLOT_W-1:0];
            nbits = NB_W'(24);
         end
         default: begin
            bits  = {b8, g8, r8};
            nbits = NB_W'(24);
         end
      endcase
   end
endmodule

// File: rtl/p2b_accum.sv
module p2b_accum
   import p2b_pkg::*;
#(
   parameter int ACC_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SLOT_W-1:0] bits,
   input  logic [NB_W-1:0]   nbits,
   input  logic              in_valid,
   input  logic              in_first,
   input  logic              in_last,
   output logic              in_ready,
   output logic [BYTE_W-1:0] out_byte,
   output logic              out_valid,
   output logic              out_last,
   output logic              out_sof,
   input  logic              out_ready
);
   localparam int CNT_W = $clog2(ACC_W + 1);

   generate
      if (ACC_W < SLOT_W + BYTE_W) begin : g_bad_acc
         $error("p2b_accum: ACC_W too small for one slot plus a partial byte");
      end
   endgenerate

   logic [ACC_W-1:0] acc;
   logic [CNT_W-1:0] fill;
   logic             end_pend, sof_pend;
   logic             take, give;

   assign in_ready  = (fill < CNT_W'(BYTE_W)) && !end_pend;
   assign out_valid = (fill >= CNT_W'(BYTE_W));
   assign out_byte  = acc[BYTE_W-1:0];
   // final byte of a line; a malformed tail shorter than a byte is dropped
   assign out_last  = end_pend && (fill < CNT_W'(2 * BYTE_W));
   assign out_sof   = sof_pend && out_valid;
   assign take      = in_valid && in_ready;
   assign give      = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         fill     <= '0;
         end_pend <= 1'b0;
         sof_pend <= 1'b0;
      end else if (take) begin
         acc      <= acc | ({{(ACC_W-SLOT_W){1'b0}}, bits} << fill);
         fill     <= fill + CNT_W'(nbits);
         end_pend <= in_last;
         sof_pend <= in_first;
      end else if (give) begin
         sof_pend <= 1'b0;
         if (out_last) begin
            acc      <= '0;
            fill     <= '0;
            end_pend <= 1'b0;
         end else begin
            acc  <= acc >> BYTE_W;
            fill <= fill - CNT_W'(BYTE_W);
         end
      end
   end
endmodule

// File: rtl/p2b_line_mon.sv
module p2b_line_mon
   import p2b_pkg::*;
#(
   parameter int LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        fmt,
   input  logic [LINE_W-1:0] line_pix,
   input  logic              s_tvalid,
   input  logic              s_tready,
   input  logic              s_tlast,
   input  logic              m_ready,
   input  logic              urun_clr,
   output logic [LINE_W+1:0] word_count,
   output logic              underrun
);
   localparam int WC_W = LINE_W + 2;
   localparam int WIDE = LINE_W + 4;

   generate
      if (LINE_W < 2) begin : g_bad_line
         $error("p2b_line_mon: LINE_W must be at least 2");
      end
   endgenerate

   logic [WIDE-1:0] wide;
   logic            in_line, starve;

   assign wide = WIDE'(line_pix);

   always_comb begin
      case (pix_fmt_e'(fmt))
         FMT_RGB565:  word_count = WC_W'(wide << 1);
         FMT_RGB666P: word_count = WC_W'((wide * WIDE'(9)) >> 2);
         default:     word_count = WC_W'(wide * WIDE'(3));
      endcase
   end

   assign starve = in_line && s_tready && !s_tvalid && m_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_line  <= 1'b0;
         underrun <= 1'b0;
      end else begin
         if (s_tvalid && s_tready) in_line <= !s_tlast;
         if (starve)               underrun <= 1'b1;
         else if (urun_clr)        underrun <= 1'b0;
      end
   end
endmodule

// File: rtl/p2b_converter.sv
module p2b_converter
   import p2b_pkg::*;
#(
   parameter int COMP_W = 8,
   parameter int LINE_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          fmt,
   input  logic [LINE_W-1:0]   line_pix,
   input  logic [3*COMP_W-1:0] s_tdata,
   input  logic                s_tvalid,
   output logic                s_tready,
   input  logic                s_tuser,
   input  logic                s_tlast,
   output logic [7:0]          m_data,
   output logic                m_valid,
   input  logic                m_ready,
   output logic                m_last,
   output logic                m_sof,
   output logic [LINE_W+1:0]   word_count,
   output logic                underrun,
   input  logic                urun_clr
);
   localparam int ACC_W = SLOT_W + BYTE_W;

   logic [SLOT_W-1:0] slot_bits;
   logic [NB_W-1:0]   slot_nbits;

   p2b_pack #(.COMP_W(COMP_W)) u_pack (
      .fmt   (fmt),
      .px    (s_tdata),
      .bits  (slot_bits),
      .nbits (slot_nbits)
   );

   p2b_accum #(.ACC_W(ACC_W)) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .bits      (slot_bits),
      .nbits     (slot_nbits),
      .in_valid  (s_tvalid),
      .in_first  (s_tuser),
      .in_last   (s_tlast),
      .in_ready  (s_tready),
      .out_byte  (m_data),
      .out_valid (m_valid),
      .out_last  (m_last),
      .out_sof   (m_sof),
      .out_ready (m_ready)
   );

   p2b_line_mon #(.LINE_W(LINE_W)) u_mon (
      .clk        (clk),
      .rst_n      (rst_n),
      .fmt        (fmt),
      .line_pix   (line_pix),
      .s_tvalid   (s_tvalid),
      .s_tready   (s_tready),
      .s_tlast    (s_tlast),
      .m_ready    (m_ready),
      .urun_clr   (urun_clr),
      .word_count (word_count),
      .underrun   (underrun)
   );
endmodule

// File: rtl/p2b_converter_chk.sv
module p2b_converter_chk #(
   parameter int COMP_W = 8,
   parameter int LINE_W = 12
) (
   input logic       clk,
   input logic       rst_n,
   input logic       s_tvalid,
   input logic       s_tready,
   input logic [7:0] m_data,
   input logic       m_valid,
   input logic       m_ready,
   input logic       m_last,
   input logic       m_sof,
   input logic       underrun,
   input logic       urun_clr
);
   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last) && $stable(m_sof));

   assert_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_tready && m_valid));

   assert_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      m_last |-> m_valid);

   assert_sof_R8: assert property (@(posedge clk) disable iff (!rst_n)
      m_sof |-> m_valid);

   assert_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underrun) |-> $past(s_tready && !s_tvalid && m_ready));

   assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      underrun && !urun_clr |=> underrun);

   assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      urun_clr && !(s_tready && !s_tvalid) |=> !underrun);
endmodule

bind p2b_converter p2b_converter_chk #(.COMP_W(COMP_W), .LINE_W(LINE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .s_tvalid (s_tvalid),
   .s_tready (s_tready),
   .m_data   (m_data),
   .m_valid  (m_valid),
   .m_ready  (m_ready),
   .m_last   (m_last),
   .m_sof    (m_sof),
   .underrun (underrun),
   .urun_clr (urun_clr)
);

// File: tb/sim_p2b_converter.sv
module sim_p2b_converter;
   localparam int COMP_W = 8;
   localparam int LINE_W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        fmt = 3'd3;
   logic [LINE_W-1:0] line_pix = '0;
   logic [23:0]       s_tdata = '0;
   logic              s_tvalid = 1'b0, s_tuser = 1'b0, s_tlast = 1'b0;
   logic              s_tready;
   logic [7:0]        m_data;
   logic              m_valid, m_last, m_sof, underrun;
   logic              m_ready = 1'b0;
   logic              urun_clr = 1'b0;
   logic [LINE_W+1:0] word_count;

   int    checks = 0, failures = 0;
   string cur_req = "R2";
   bit    force_rdy = 1'b0, done = 1'b0;
   logic [9:0] exp_q[$];   // {sof, last, byte}

   always #2 clk = ~clk;   // 250 MHz

   p2b_converter #(.COMP_W(COMP_W), .LINE_W(LINE_W)) u0 (
      .clk(clk), .rst_n(rst_n), .fmt(fmt), .line_pix(line_pix),
      .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
      .s_tuser(s_tuser), .s_tlast(s_tlast), .m_data(m_data),
      .m_valid(m_valid), .m_ready(m_ready), .m_last(m_last), .m_sof(m_sof),
      .word_count(word_count), .underrun(underrun), .urun_clr(urun_clr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // output side: random back-pressure, compare each transferred byte
   always @(negedge clk) begin
      if (rst_n && !done) begin
         m_ready = force_rdy ? 1'b1 : ($urandom_range(9) < 7);
         if (m_valid && m_ready) begin
            if (exp_q.size() == 0) chk(1'b0, "R12", m_data, -1);
            else begin
               logic [9:0] e;
               e = exp_q.pop_front();
               chk(m_data == e[7:0], cur_req, m_data, e[7:0]);
               chk(m_last == e[8], "R7", m_last, e[8]);
               chk(m_sof == e[9], "R8", m_sof, e[9]);
            end
         end
      end
   end

   function automatic int exp_wc(input int f, input int n);
      if (f == 0) return 2 * n;
      if (f == 1) return (9 * n) / 4;
      return 3 * n;
   endfunction

   task automatic send_line(input int f, input int n, input bit sof,
                            input int gap_at, input int gap_len);
      logic [23:0] pix[64];
      logic [7:0]  by[200];
      int          nb = 0;
      for (int i = 0; i < n; i++) pix[i] = 24'($urandom);
      for (int i = 0; i < n; i++) begin
         logic [7:0] g, b, r;
         g = pix[i][7:0]; b = pix[i][15:8]; r = pix[i][23:16];
         case (f)
            0: begin   // R3
               logic [15:0] w;
               w = {b[7:3], g[7:2], r[7:3]};
               by[nb] = w[7:0]; by[nb+1] = w[15:8]; nb += 2;
            end
            1: if (i % 4 == 3) begin   // R4
               logic [71:0] grp;
               for (int k = 0; k < 4; k++)
                  grp[18*k +: 18] = {pix[i-3+k][15:10], pix[i-3+k][7:2], pix[i-3+k][23:18]};
               for (int j = 0; j < 9; j++) by[nb+j] = grp[8*j +: 8];
               nb += 9;
            end
            2: begin   // R5
               by[nb] = {r[7:2], 2'b00}; by[nb+1] = {g[7:2], 2'b00};
               by[nb+2] = {b[7:2], 2'b00}; nb += 3;
            end
            4: begin   // R6
               by[nb] = pix[i][7:0]; by[nb+1] = pix[i][15:8];
               by[nb+2] = pix[i][23:16]; nb += 3;
            end
            default: begin   // R2
               by[nb] = r; by[nb+1] = g; by[nb+2] = b; nb += 3;
            end
         endcase
      end
      for (int j = 0; j < nb; j++)
         exp_q.push_back({(sof && j == 0), (j == nb - 1), by[j]});
      fmt = 3'(f);
      line_pix = LINE_W'(n);
      @(negedge clk);
      chk(int'(word_count) == exp_wc(f, n), "R9", word_count, exp_wc(f, n));
      chk(nb == exp_wc(f, n), "R9", nb, exp_wc(f, n));
      for (int i = 0; i < n; i++) begin
         if (i == gap_at) begin
            s_tvalid = 1'b0;
            repeat (gap_len) @(negedge clk);
         end
         s_tvalid = 1'b1; s_tdata = pix[i];
         s_tuser = sof && (i == 0); s_tlast = (i == n - 1);
         while (!s_tready) @(negedge clk);
         @(negedge clk);
      end
      s_tvalid = 1'b0; s_tuser = 1'b0; s_tlast = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (4) @(negedge clk);
      chk(m_valid == 1'b0, "R1", m_valid, 0);
      chk(underrun == 1'b0, "R1", underrun, 0);
      chk(s_tready == 1'b1, "R1", s_tready, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int f = 0; f < 5; f++) begin
         case (f)
            0: cur_req = "R3";
            1: cur_req = "R4";
            2: cur_req = "R5";
            3: cur_req = "R2";
            default: cur_req = "R6";
         endcase
         // shortest legal line first, then random lengths
         send_line(f, (f == 1) ? 4 : 1, 1'b1, -1, 0);
         for (int l = 0; l < 6; l++) begin
            int n;
            n = (f == 1) ? 4 * (1 + $urandom_range(7)) : 1 + $urandom_range(19);
            send_line(f, n, (l == 3), -1, 0);
            repeat ($urandom_range(3)) @(negedge clk);
         end
         drain();
         chk(underrun == 1'b0, "R10", underrun, 0);   // idle gaps between lines
      end

      // directed underrun: starve input mid-line with output ready
      cur_req = "R2";
      force_rdy = 1'b1;
      send_line(3, 4, 1'b1, 1, 12);
      drain();
      chk(underrun == 1'b1, "R10", underrun, 1);
      repeat (5) @(negedge clk);
      chk(underrun == 1'b1, "R11", underrun, 1);
      urun_clr = 1'b1;
      @(negedge clk);
      urun_clr = 1'b0;
      chk(underrun == 1'b0, "R11", underrun, 0);
      force_rdy = 1'b0;

      // back-pressure heavy lines in packed format after the clear
      cur_req = "R4";
      send_line(1, 32, 1'b1, -1, 0);
      drain();
      chk(underrun == 1'b0, "R10", underrun, 0);
      chk(exp_q.size() == 0, "R12", exp_q.size(), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         failures++;
         checks++;
         $display("FAIL R12 watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule